// File: doc/BRIEF.md
# Receive Message FIFO with Host Status Word

This block holds frames that a serial-bus protocol engine has received and filtered, until the host takes them out. The engine offers one frame per cycle on a store port. A frame flagged as a null frame is turned away when the null-rejection input is high. The host takes the oldest message from a show-ahead read port with a one-cycle pop strobe.

A 32-bit status word tells the host whether messages are waiting and how many there are. It also shows whether the fill level has reached a programmable critical threshold, and whether a frame was lost because the FIFO was full. Two sticky service-request flags record new arrivals and the upward crossing of the threshold. Each flag drives the interrupt output when its enable is set, and the host clears a flag by writing a one to it.

The protocol engine pulses an input when the controller leaves its configuration state, and another when it enters its startup state. Either pulse empties the FIFO and zeroes all status and request flags, without any global reset.

Top module: `rx_msg_fifo`

## Requirements
- R1: A frame offered with `st_vld`=1 is accepted unless `st_null`=1 and `null_reject`=1. An accepted frame that finds room raises the fill level by one after the clock edge, and sets status bit 0 (not-empty).
- R2: Every frame written into the FIFO sets service-request flag `sr_flags[0]` at the same edge.
- R3: Status bit 0 stays 1 until the host has popped the last stored message. A pop while the FIFO is empty changes nothing.
- R4: Status bit 1 (critical) is 1 exactly while the fill level is greater than or equal to `crit_lvl`, whether the level is rising or falling.
- R5: When status bit 1 goes from 0 to 1, `sr_flags[1]` is set at the following clock edge. It is not set when the bit falls.
- R6: An accepted frame that arrives while the FIFO holds DEPTH messages, with no pop in the same cycle, is discarded. The fill level stays at DEPTH, the stored messages are kept, and status bit 2 (overflow) is set.
- R7: A cycle with `clr_wr`=1 clears each flag whose `clr_mask` bit is 1: bit 0 clears `sr_flags[0]`, bit 1 clears `sr_flags[1]`, and bit 2 clears status bit 2. A set event in the same cycle wins over the clear.
- R8: `irq` is 1 while any service-request flag with its `sr_en` bit set is 1.
- R9: A cycle with `leave_cfg`=1 or `enter_startup`=1 empties the FIFO and clears the fill level, status bits 0 and 2, and both service-request flags, overriding every other input.
- R10: Status word layout: bit 0 not-empty, bit 1 critical, bit 2 overflow, bits 15:8 fill level zero-extended, and all other bits zero.
- R11: A store and a pop in the same cycle on a non-empty FIFO leave the fill level unchanged. When the FIFO is full, that store is kept and not counted as an overflow.
- R12: `rd_data` always shows the oldest stored message, and messages leave in the order they were stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| st_vld | input | 1 | Frame offered for storage |
| st_null | input | 1 | Offered frame is a null frame |
| st_data | input | DW | Offered frame contents |
| null_reject | input | 1 | 1: null frames are not stored |
| rd_pop | input | 1 | Host removes the oldest message |
| rd_data | output | DW | Oldest stored message |
| crit_lvl | input | LVL_W | Critical fill threshold |
| leave_cfg | input | 1 | Controller leaves configuration state |
| enter_startup | input | 1 | Controller enters startup state |
| clr_wr | input | 1 | Host write-one-to-clear strobe |
| clr_mask | input | 3 | Flags to clear: sr0, sr1, overflow |
| sr_en | input | 2 | Interrupt enables for the two request flags |
| status | output | 32 | Status word |
| sr_flags | output | 2 | Sticky service-request flags |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall in the same cycle: a store with a host pop, and a flag-setting store with a host clear of that same flag. The bench triggers the first pair both on a partly filled FIFO and on a full one. It judges the result from the fill level, which must stay unchanged, from status bit 2, which must stay clear, and from the order in which messages come out afterwards. It triggers the second pair by pulsing `clr_wr` on `sr_flags[0]` in the cycle of a store, and expects the flag to read 1 afterwards.

// File: rtl/rx_msg_fifo.sv
module rx_msg_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             st_vld,
  input  logic             st_null,
  input  logic [DW-1:0]    st_data,
  input  logic             null_reject,
  input  logic             rd_pop,
  output logic [DW-1:0]    rd_data,
  input  logic [LVL_W-1:0] crit_lvl,
  input  logic             leave_cfg,
  input  logic             enter_startup,
  input  logic             clr_wr,
  input  logic [2:0]       clr_mask,
  input  logic [1:0]       sr_en,
  output logic [31:0]      status,
  output logic [1:0]       sr_flags,
  output logic             irq
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [LVL_W-1:0] cnt;
  logic             ovf, crit_q;

  wire proto_clr = leave_cfg | enter_startup;
  wire accept    = st_vld & ~(st_null & null_reject);
  wire full      = (cnt == LVL_W'(DEPTH));
  wire do_pop    = rd_pop & (cnt != '0);
  wire do_push   = accept & (~full | do_pop);
  wire crit      = (cnt >= crit_lvl);
  wire [2:0] clr = clr_wr ? clr_mask : 3'b000;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk)
    if (do_push && !proto_clr) mem[wp] <= st_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      ovf <= 1'b0; crit_q <= 1'b0; sr_flags <= '0;
    end else if (proto_clr) begin
      wp <= '0; rp <= '0; cnt <= '0;
      ovf <= 1'b0; crit_q <= 1'b0; sr_flags <= '0;
    end else begin
      if (do_push) wp <= adv(wp);
      if (do_pop)  rp <= adv(rp);
      cnt         <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
      ovf         <= (ovf & ~clr[2]) | (accept & full & ~do_pop);
      crit_q      <= crit;
      sr_flags[0] <= (sr_flags[0] & ~clr[0]) | do_push;
      sr_flags[1] <= (sr_flags[1] & ~clr[1]) | (crit & ~crit_q);
    end
  end

  assign rd_data = mem[rp];
  assign status  = {16'h0, {(8-LVL_W){1'b0}}, cnt, 5'b0, ovf, crit, cnt != '0};
  assign irq     = |(sr_flags & sr_en);
endmodule

module rx_msg_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        st_vld,
  input logic        st_null,
  input logic        null_reject,
  input logic        rd_pop,
  input logic        leave_cfg,
  input logic        enter_startup,
  input logic [31:0] status,
  input logic [1:0]  sr_flags
);
  wire       pc   = leave_cfg | enter_startup;
  wire       acc  = st_vld & ~(st_null & null_reject);
  wire [7:0] fill = status[15:8];

  a_r1_store_sets_ne: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fill < 8'(DEPTH) && !pc) |=> status[0]);
  a_r2_store_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fill < 8'(DEPTH) && !pc) |=> sr_flags[0]);
  a_r5_rise_sets_req: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status[1]) && !pc) |=> sr_flags[1]);
  a_r6_full_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fill == 8'(DEPTH) && !rd_pop && !pc) |=> (status[2] && fill == 8'(DEPTH)));
  a_r9_proto_clear: assert property (@(posedge clk) disable iff (!rst_n)
    pc |=> (fill == 8'd0 && !status[0] && !status[2] && sr_flags == 2'b00));
  a_r10_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (status[31:16] == 16'h0 && status[7:3] == 5'h0 && fill <= 8'(DEPTH)));
  a_r11_push_pop_level: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rd_pop && fill != 8'd0 && !pc) |=> $stable(fill));
endmodule

bind rx_msg_fifo rx_msg_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_null(st_null),
  .null_reject(null_reject), .rd_pop(rd_pop), .leave_cfg(leave_cfg),
  .enter_startup(enter_startup), .status(status), .sr_flags(sr_flags));

// File: tb/test_rx_msg_fifo.sv
module test_rx_msg_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int DW = 32;
  localparam int LVL_W = 4;
  // vector: st, null, pop, data[7:0], exp_fill[3:0], exp_rd[7:0]
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {3'b100, 8'hA1, 4'd1, 8'hA1},
    {3'b100, 8'hA2, 4'd2, 8'hA1},
    {3'b110, 8'hA3, 4'd2, 8'hA1},   // R1 null rejected
    {3'b001, 8'h00, 4'd1, 8'hA2},
    {3'b101, 8'hA4, 4'd1, 8'hA4},   // R11
    {3'b100, 8'hA5, 4'd2, 8'hA4},
    {3'b001, 8'h00, 4'd1, 8'hA5},   // R12
    {3'b001, 8'h00, 4'd0, 8'h00},
    {3'b001, 8'h00, 4'd0, 8'h00},   // R3 pop on empty
    {3'b101, 8'hA6, 4'd1, 8'hA6}
  };

  logic clk = 0, rst_n = 0;
  logic st_vld = 0, st_null = 0, null_reject = 1, rd_pop = 0;
  logic [DW-1:0] st_data = '0, rd_data;
  logic [LVL_W-1:0] crit_lvl = 4'd7;
  logic leave_cfg = 0, enter_startup = 0, clr_wr = 0;
  logic [2:0] clr_mask = 0;
  logic [1:0] sr_en = 0, sr_flags;
  logic [31:0] status;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_msg_fifo #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) i_rx_msg_fifo (
    .clk(clk), .rst_n(rst_n), .st_vld(st_vld), .st_null(st_null), .st_data(st_data),
    .null_reject(null_reject), .rd_pop(rd_pop), .rd_data(rd_data), .crit_lvl(crit_lvl),
    .leave_cfg(leave_cfg), .enter_startup(enter_startup), .clr_wr(clr_wr),
    .clr_mask(clr_mask), .sr_en(sr_en), .status(status), .sr_flags(sr_flags), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic st, input logic nl, input logic pp, input logic [7:0] d);
    st_vld = st; st_null = nl; rd_pop = pp; st_data = {24'h0, d};
    @(posedge clk); #1;
    st_vld = 0; st_null = 0; rd_pop = 0; clr_wr = 0; clr_mask = 0;
    leave_cfg = 0; enter_startup = 0;
  endtask

  function automatic logic [7:0] lvl(input logic [31:0] s);
    return s[15:8];
  endfunction

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3) rst_n = 1;
    @(posedge clk); #1;
    chk("R10 reset status", status, 32'h0);
    chk("R10 reset req", {30'h0, sr_flags}, 32'h0);
    chk("R8 reset irq", {31'h0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][22], VEC[i][21], VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R1/R11 vec%0d fill", i), {24'h0, lvl(status)}, {28'h0, VEC[i][11:8]});
      chk($sformatf("R3 vec%0d ne", i), {31'h0, status[0]}, {31'h0, VEC[i][11:8] != 0});
      if (VEC[i][11:8] != 0)
        chk($sformatf("R12 vec%0d data", i), rd_data, {24'h0, VEC[i][7:0]});
    end
    chk("R2 store req", {31'h0, sr_flags[0]}, 32'h1);

    enter_startup = 1; step(1, 0, 0, 8'hBB);
    chk("R9 startup status", status, 32'h0);
    chk("R9 startup req", {30'h0, sr_flags}, 32'h0);

    null_reject = 0; step(1, 1, 0, 8'hB1);
    chk("R1 null accepted", {24'h0, lvl(status)}, 32'd1);
    chk("R10 layout one msg", status, 32'h0000_0101);
    leave_cfg = 1; step(0, 0, 0, 8'h0);
    chk("R9 leave cfg", status, 32'h0);

    crit_lvl = 4'd3;
    step(1, 0, 0, 8'h11); step(1, 0, 0, 8'h12);
    chk("R4 below crit", {31'h0, status[1]}, 32'h0);
    step(1, 0, 0, 8'h13);
    chk("R4 at crit", {31'h0, status[1]}, 32'h1);
    chk("R5 req not yet", {31'h0, sr_flags[1]}, 32'h0);
    step(0, 0, 0, 8'h0);
    chk("R5 req set", {31'h0, sr_flags[1]}, 32'h1);
    step(0, 0, 1, 8'h0);
    chk("R4 drop below", {31'h0, status[1]}, 32'h0);
    chk("R5 req sticky", {31'h0, sr_flags[1]}, 32'h1);

    sr_en = 2'b10; #1;
    chk("R8 irq enabled", {31'h0, irq}, 32'h1);
    sr_en = 2'b00; #1;
    chk("R8 irq masked", {31'h0, irq}, 32'h0);

    clr_wr = 1; clr_mask = 3'b010; step(0, 0, 0, 8'h0);
    chk("R7 clear req1", {30'h0, sr_flags}, 32'h1);
    clr_wr = 1; clr_mask = 3'b001; step(1, 0, 0, 8'h14);
    chk("R7 set wins", {31'h0, sr_flags[0]}, 32'h1);

    for (int d = 8'h15; d <= 8'h19; d++) step(1, 0, 0, 8'(d));
    chk("R6 full level", {24'h0, lvl(status)}, 32'd8);
    chk("R6 no ovf yet", {31'h0, status[2]}, 32'h0);
    step(1, 0, 0, 8'hEE);
    chk("R6 overflow flag", {31'h0, status[2]}, 32'h1);
    chk("R6 level held", {24'h0, lvl(status)}, 32'd8);
    clr_wr = 1; clr_mask = 3'b100; step(0, 0, 0, 8'h0);
    chk("R7 clear ovf", {31'h0, status[2]}, 32'h0);
    step(1, 0, 1, 8'h20);
    chk("R11 full push pop level", {24'h0, lvl(status)}, 32'd8);
    chk("R11 full push pop no ovf", {31'h0, status[2]}, 32'h0);

    for (int k = 0; k < 8; k++) begin
      chk($sformatf("R12 drain %0d", k), rd_data, (k == 7) ? 32'h20 : 32'(8'h13 + k));
      step(0, 0, 1, 8'h0);
    end
    chk("R3 empty after drain", {31'h0, status[0]}, 32'h0);
    step(0, 0, 1, 8'h0);
    chk("R3 pop on empty", {24'h0, lvl(status)}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule